// File: doc/BRIEF.md
# Register-Mapped Stream Link Bridge

This block sits on a simple processor register bus and moves 32-bit words between software and up to eight outgoing and eight incoming stream links. Every link owns a FIFO. All outgoing links share one power-of-two depth, and all incoming links share another. Software pushes a word onto outgoing link i by writing data register i. It pops a word from incoming link i by reading the same register. Each link carries a valid/ready handshake and an end-of-packet flag, and the flag is queued in the FIFO together with its word.

The flag for an outgoing word is armed through a per-link bit in the status register before the data write. The bit clears itself once the word has entered the FIFO. For incoming links, the status register shows whether the word at the head of each FIFO was tagged as last. The control register holds the global enable and reports the two configured FIFO depths as base-2 logarithms.

Clearing the enable flushes every FIFO and all internal state. Bus reads return their data one clock after the read strobe. Addresses are byte offsets, and bits 1:0 are ignored.

Top module: `mm_stream_bridge`

## Requirements
- R1: The control register at offset 0x00 holds the enable in bit 0, which is read/write and 0 after reset. Bits 11:8 read log2 of the outgoing FIFO depth and bits 15:12 read log2 of the incoming FIFO depth. Bits 7:1 and 31:16 read zero.
- R2: The status register at offset 0x10 has four fields: bits 7:0 are per-incoming-link "FIFO not empty", bits 15:8 are per-outgoing-link "FIFO not full", bits 23:16 are per-incoming-link "head word is last", and bits 31:24 are the per-outgoing-link end-of-packet arm bits. Only bits 31:24 are writable. Every flag reads 0 while the block is disabled and for links that are not built.
- R3: A write to offset 0x20+4*i queues the word on outgoing link i. The link asserts valid while its FIFO holds data, and words leave in write order, one on every clock where valid and ready are both high. Data, valid and last do not change while ready is low.
- R4: A data write to an outgoing link whose FIFO is full is dropped, and the words already queued are unchanged.
- R5: An arm bit set in status bits 31:24 tags the next word written to that link. The bit clears once that word has entered the FIFO, and the link's last output is high exactly while that word is at the head.
- R6: A read of offset 0x20+4*i pops incoming link i in arrival order. A read from an empty incoming FIFO changes nothing and returns the last word popped from that link.
- R7: An incoming link drives ready low while its FIFO is full, and it accepts a word only on a clock where valid and ready are both high.
- R8: Outgoing links with index NUM_TX or higher, and incoming links with index NUM_RX or higher, drive all their outputs to zero. Reads of their data registers return zero, and writes to them have no effect.
- R9: Clearing the enable empties every FIFO and clears the arm bits and held read words. While the block is disabled, no outgoing valid and no incoming ready is driven.
- R10: Offsets other than control, status and the eight data registers read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after bus_re |
| tx_data | output | 256 | Outgoing word, 32 bits per link, link i at [32i+31:32i] |
| tx_valid | output | 8 | Outgoing word valid, one bit per link |
| tx_ready | input | 8 | Sink accepts the outgoing word |
| tx_last | output | 8 | Outgoing word ends a packet |
| rx_data | input | 256 | Incoming word, 32 bits per link |
| rx_valid | input | 8 | Incoming word valid |
| rx_ready | output | 8 | Bridge can take an incoming word |
| rx_last | input | 8 | Incoming word ends a packet |

## Verification
The outgoing side is tested in three ways:
- A queue drained only after a stall, which shows that the head word is held while ready is low and that words leave in write order.
- An overfill by one word, which shows that the dropped write leaves the queued words and the free flag intact.
- An armed word followed by an untagged one, which shows that the tag travels with its own word only.

The incoming side is tested with two patterns:
- A tagged pair followed by an extra read, which shows head-tag reporting and the repeat of the last word on an empty read.
- A continuous stream longer than the FIFO, which shows that ready drops at full and that no word is lost or duplicated.

Further tests cover the unbuilt links, the disable flush and the unmapped offsets.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int MAX_LINKS = 8;
  localparam int WORD_W    = 32;

  typedef struct packed {
    logic              last;
    logic [WORD_W-1:0] data;
  } sbr_word_t;

  // register select = bus_addr[5:2]
  localparam logic [3:0] SEL_CTRL = 4'h0;
  localparam logic [3:0] SEL_STAT = 4'h4;

  function automatic int unsigned depth_log2(input int unsigned d);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < d) r++;
    return r;
  endfunction

  function automatic logic [MAX_LINKS-1:0] link_mask(input int unsigned n);
    logic [MAX_LINKS-1:0] m;
    for (int k = 0; k < MAX_LINKS; k++) m[k] = (k < n);
    return m;
  endfunction
endpackage

// File: rtl/sbr_fifo.sv
module sbr_fifo
  import sbr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      push,
  input  sbr_word_t din,
  input  logic      pop,
  output sbr_word_t dout,
  output logic      empty,
  output logic      full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  sbr_word_t       mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic            do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R4
  AST_FULL_DROPS_PUSH: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (full && push && !pop) |=> (full && $stable(wp))); // R4
endmodule

// File: rtl/sbr_tx_chan.sv
module sbr_tx_chan
  import sbr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              eop,
  output logic              accepted,
  output logic              not_full,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last
);
  sbr_word_t head, in_word;
  logic      empty, full, fire;

  assign in_word  = '{last: eop, data: wdata};
  assign fire     = tx_valid && tx_ready;
  assign accepted = en && wr && !full;
  assign not_full = en && !full;
  assign tx_valid = en && !empty;
  assign tx_data  = tx_valid ? head.data : '0;
  assign tx_last  = tx_valid ? head.last : 1'b0;

  sbr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(!en),
    .push(accepted), .din(in_word),
    .pop(fire), .dout(head),
    .empty(empty), .full(full)
  );

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R3
endmodule

// File: rtl/sbr_rx_chan.sv
module sbr_rx_chan
  import sbr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rd,
  output logic [WORD_W-1:0] rd_value,
  output logic              avail,
  output logic              head_last,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_last
);
  sbr_word_t         head, in_word;
  logic              empty, full, fire, take;
  logic [WORD_W-1:0] held;

  assign in_word   = '{last: rx_last, data: rx_data};
  assign rx_ready  = en && !full;
  assign fire      = rx_valid && rx_ready;
  assign avail     = en && !empty;
  assign take      = rd && avail;
  assign head_last = avail && head.last;
  assign rd_value  = avail ? head.data : held;

  sbr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(!en),
    .push(fire), .din(in_word),
    .pop(take), .dout(head),
    .empty(empty), .full(full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !en) held <= '0;
    else if (take)     held <= head.data;
  end

  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (rd && !avail) |=> $stable(held)); // R6
endmodule

// File: rtl/mm_stream_bridge.sv
module mm_stream_bridge
  import sbr_pkg::*;
#(
  parameter int NUM_TX   = 8,
  parameter int NUM_RX   = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_we,
  input  logic                        bus_re,
  input  logic [5:0]                  bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic [MAX_LINKS*WORD_W-1:0] tx_data,
  output logic [MAX_LINKS-1:0]        tx_valid,
  input  logic [MAX_LINKS-1:0]        tx_ready,
  output logic [MAX_LINKS-1:0]        tx_last,
  input  logic [MAX_LINKS*WORD_W-1:0] rx_data,
  input  logic [MAX_LINKS-1:0]        rx_valid,
  output logic [MAX_LINKS-1:0]        rx_ready,
  input  logic [MAX_LINKS-1:0]        rx_last
);
  localparam int unsigned TX_LOG = depth_log2(TX_DEPTH);
  localparam int unsigned RX_LOG = depth_log2(RX_DEPTH);
  localparam logic [MAX_LINKS-1:0] TX_MASK = link_mask(NUM_TX);

  logic                 en_q;
  logic [MAX_LINKS-1:0] arm_q;
  logic [WORD_W-1:0]    rdata_q;
  logic [3:0]           sel;
  logic                 is_data;
  logic [2:0]           idx;

  logic [MAX_LINKS-1:0] tx_wr, tx_acc, tx_free;
  logic [MAX_LINKS-1:0] rx_rd, rx_avail, rx_head_last;
  logic [MAX_LINKS-1:0][WORD_W-1:0] rx_value;
  logic [WORD_W-1:0]    ctrl_word, stat_word;

  assign sel     = bus_addr[5:2];
  assign is_data = sel[3];
  assign idx     = sel[2:0];

  for (genvar i = 0; i < MAX_LINKS; i++) begin : g_link
    assign tx_wr[i] = en_q && bus_we && is_data && (idx == 3'(i));
    assign rx_rd[i] = en_q && bus_re && is_data && (idx == 3'(i));

    if (i < NUM_TX) begin : g_tx
      sbr_tx_chan #(.DEPTH(TX_DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .wr(tx_wr[i]), .wdata(bus_wdata), .eop(arm_q[i]),
        .accepted(tx_acc[i]), .not_full(tx_free[i]),
        .tx_data(tx_data[i*WORD_W +: WORD_W]), .tx_valid(tx_valid[i]),
        .tx_ready(tx_ready[i]), .tx_last(tx_last[i])
      );
    end else begin : g_tx_off
      assign tx_acc[i]                   = 1'b0;
      assign tx_free[i]                  = 1'b0;
      assign tx_data[i*WORD_W +: WORD_W] = '0;
      assign tx_valid[i]                 = 1'b0;
      assign tx_last[i]                  = 1'b0;
    end

    if (i < NUM_RX) begin : g_rx
      sbr_rx_chan #(.DEPTH(RX_DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .rd(rx_rd[i]), .rd_value(rx_value[i]),
        .avail(rx_avail[i]), .head_last(rx_head_last[i]),
        .rx_data(rx_data[i*WORD_W +: WORD_W]), .rx_valid(rx_valid[i]),
        .rx_ready(rx_ready[i]), .rx_last(rx_last[i])
      );
    end else begin : g_rx_off
      assign rx_value[i]     = '0;
      assign rx_avail[i]     = 1'b0;
      assign rx_head_last[i] = 1'b0;
      assign rx_ready[i]     = 1'b0;
    end
  end

  assign ctrl_word = {16'd0, 4'(RX_LOG), 4'(TX_LOG), 7'd0, en_q};
  assign stat_word = {arm_q, rx_head_last, tx_free, rx_avail};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      arm_q <= '0;
    end else begin
      if (bus_we && sel == SEL_CTRL) en_q <= bus_wdata[0];
      if (!en_q) arm_q <= '0;
      else if (bus_we && sel == SEL_STAT) arm_q <= bus_wdata[31:24] & TX_MASK;
      else arm_q <= arm_q & ~tx_acc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_re) begin
      if (is_data)              rdata_q <= rx_value[idx];
      else if (sel == SEL_CTRL) rdata_q <= ctrl_word;
      else if (sel == SEL_STAT) rdata_q <= stat_word;
      else                      rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_acc) |=> ((arm_q & $past(tx_acc)) == '0)); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (tx_valid == '0 && rx_ready == '0)); // R9
  AST_UNBUILT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_valid & ~TX_MASK) == '0)); // R8
endmodule

// File: tb/tb_mm_stream_bridge.sv
`timescale 1ns/1ps
module tb_mm_stream_bridge;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         bus_we = 0, bus_re = 0;
  logic [5:0]   bus_addr = 0;
  logic [31:0]  bus_wdata = 0;
  logic [31:0]  bus_rdata;
  logic [255:0] tx_data;
  logic [7:0]   tx_valid, tx_last, rx_ready;
  logic [7:0]   tx_ready = 0, rx_valid = 0, rx_last = 0;
  logic [255:0] rx_data = 0;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mm_stream_bridge #(.NUM_TX(6), .NUM_RX(5), .TX_DEPTH(4), .RX_DEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_last(rx_last)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  // sink ready held high; expects words in order, one per cycle
  task automatic drain(input int ln, input string req, input logic [31:0] first,
                       input int n, input logic [31:0] last_mask);
    @(negedge clk); tx_ready[ln] = 1;
    for (int k = 0; k < n; k++) begin
      chk(req, {31'd0, tx_valid[ln]}, 32'd1);
      chk(req, tx_data[ln*32 +: 32], first + 32'(k));
      chk(req, {31'd0, tx_last[ln]}, {31'd0, last_mask[k]});
      @(negedge clk);
    end
    chk(req, {31'd0, tx_valid[ln]}, 32'd0);
    tx_ready[ln] = 0;
  endtask

  task automatic t_reset_ctrl;
    logic [31:0] v;
    brd(6'h00, v); chk("R1 ctrl after reset", v, 32'h0000_3200);
    brd(6'h10, v); chk("R2 status while disabled", v, 32'h0);
    bwr(6'h00, 32'hFFFF_FFFF);
    brd(6'h00, v); chk("R1 ctrl reserved bits", v, 32'h0000_3201);
    brd(6'h10, v); chk("R2 status after enable", v, 32'h0000_3F00);
  endtask

  task automatic t_tx_order;
    for (int k = 0; k < 3; k++) bwr(6'h24, 32'hA0 + 32'(k));
    repeat (3) @(negedge clk);
    chk("R3 valid held while stalled", {31'd0, tx_valid[1]}, 32'd1);
    chk("R3 head stable while stalled", tx_data[63:32], 32'hA0);
    drain(1, "R3 drain order", 32'hA0, 3, 32'h0);
  endtask

  task automatic t_tx_full;
    logic [31:0] v;
    for (int k = 0; k < 5; k++) bwr(6'h28, 32'hB0 + 32'(k));
    brd(6'h10, v); chk("R4 free flag clear when full", {31'd0, v[10]}, 32'd0);
    drain(2, "R4 dropped write", 32'hB0, 4, 32'h0);
  endtask

  task automatic t_tx_eop;
    logic [31:0] v;
    bwr(6'h10, 32'h0100_00FF);
    brd(6'h10, v); chk("R5 arm bit set", v[31:24], 32'h01);
    bwr(6'h20, 32'hC0);
    brd(6'h10, v); chk("R5 arm bit self-clears", v[31:24], 32'h00);
    bwr(6'h20, 32'hC1);
    drain(0, "R5 last follows word", 32'hC0, 2, 32'h1);
  endtask

  task automatic t_rx_basic;
    logic [31:0] v;
    @(negedge clk); rx_valid[0] = 1; rx_data[31:0] = 32'hD0; rx_last[0] = 0;
    @(negedge clk); rx_data[31:0] = 32'hD1; rx_last[0] = 1;
    @(negedge clk); rx_valid[0] = 0; rx_last[0] = 0;
    brd(6'h10, v); chk("R2 rx avail and head tag", {v[16], v[0]}, 32'h1);
    brd(6'h20, v); chk("R6 first pop", v, 32'hD0);
    brd(6'h10, v); chk("R2 head tagged last", {v[16], v[0]}, 32'h3);
    brd(6'h20, v); chk("R6 second pop", v, 32'hD1);
    brd(6'h10, v); chk("R6 empty after pops", v[7:0], 32'h0);
    brd(6'h20, v); chk("R6 empty read repeats last word", v, 32'hD1);
  endtask

  task automatic t_rx_full;
    logic [31:0] v;
    int taken = 0;
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      rx_valid[1] = 1; rx_data[63:32] = 32'hE0 + 32'(taken);
      if (rx_ready[1]) taken++;
    end
    @(negedge clk); rx_valid[1] = 0;
    chk("R7 ready low when full", {31'd0, rx_ready[1]}, 32'd0);
    chk("R7 accepted count", 32'(taken), 32'd8);
    for (int k = 0; k < 8; k++) begin
      brd(6'h24, v); chk("R7 stream order", v, 32'hE0 + 32'(k));
    end
  endtask

  task automatic t_unbuilt;
    logic [31:0] v;
    bwr(6'h38, 32'h1234);
    chk("R8 unbuilt tx valid", {24'd0, tx_valid & 8'hC0}, 32'd0);
    chk("R8 unbuilt tx data", tx_data[223:192] | tx_data[255:224], 32'd0);
    chk("R8 unbuilt rx ready", {24'd0, rx_ready & 8'hE0}, 32'd0);
    brd(6'h38, v); chk("R8 unbuilt data read", v, 32'd0);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    bwr(6'h10, 32'h0800_0000);
    bwr(6'h2C, 32'hF0);
    @(negedge clk); rx_valid[2] = 1; rx_data[95:64] = 32'hF1;
    @(negedge clk); rx_valid[2] = 0;
    bwr(6'h10, 32'h1000_0000);
    bwr(6'h00, 32'h0);
    chk("R9 no tx valid while off", {24'd0, tx_valid}, 32'd0);
    chk("R9 no rx ready while off", {24'd0, rx_ready}, 32'd0);
    brd(6'h10, v); chk("R9 status cleared", v, 32'd0);
    bwr(6'h00, 32'h1);
    brd(6'h10, v); chk("R9 fifos flushed", v, 32'h0000_3F00);
    brd(6'h28, v); chk("R9 held word cleared", v, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    bwr(6'h04, 32'hFFFF_FFFF);
    bwr(6'h18, 32'hFFFF_FFFF);
    brd(6'h04, v); chk("R10 unmapped read", v, 32'd0);
    brd(6'h1C, v); chk("R10 unmapped read", v, 32'd0);
    brd(6'h10, v); chk("R10 status untouched", v, 32'h0000_3F00);
    brd(6'h00, v); chk("R10 ctrl untouched", v, 32'h0000_3201);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_ctrl();
    t_tx_order();
    t_tx_full();
    t_tx_eop();
    t_rx_basic();
    t_rx_full();
    t_unbuilt();
    t_disable();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule